// File: doc/BRIEF.md
# Memory Clock Retune Sequencer

This block walks an external DDR memory interface through a change of its clock frequency without losing memory contents. A single start pulse, together with a requested frequency in kHz, launches a fixed, handshake-gated sequence:

1. Park the DRAM in self-refresh.
2. Stream a frequency-dependent set of timing words into the memory controller through a simple register-write port.
3. Move the memory clock onto the crystal.
4. Hold the interface DLL in reset and program a new fractional/integer divider pair.
5. Return the clock to the PLL and wait for the DLL to relock.
6. Release the DRAM from self-refresh.

Every wait is bounded by a programmable cycle limit. When a limit expires, the block raises a sticky error flag and steers the hardware back to a safe state. That state has the clock on the PLL path, the DLL released and self-refresh dropped.

The memory controller, the PLL and the clock multiplexer lie outside the block. The block sees them only through four status inputs and drives them through its control outputs. Register writes are issued one per cycle and are assumed always accepted.

Top module: `mclk_retune_seq`

## Requirements
- R1: No timing write and no clock change happens until `sref_req` is high and `dram_halted` has been seen high; every cycle with `reg_wr` high also has `sref_req` and `dram_halted` high.
- R2: The timing table number is picked from the requested kHz value as follows:
  - up to 24000 → 0
  - up to 48000 → 1
  - up to 80000 → 2 (the 60000 and 80000 slots share it)
  - up to 96000 → 3
  - up to 120000 → 4
  - anything larger → 5 (the 133000 slot and everything above it share it)
- R3: The word written to register index i from table t is `((t+1) << 24) | (i << 16) | ((i*(t+1)) mod 65536)`.
- R4: A run issues exactly 15 writes on consecutive cycles, in the index order 21, 4, 19, 7, 33, 12, 26, 13, 15, 34, 17, 32, 18, 20, 40; index 40 is always the final write.
- R5: After the last write, `bypass_sel` rises. Once the crystal-busy flag clears, both DLL resets go high and the divider outputs take their new value. The divider outputs change only while `bypass_sel`, `dll_rst` and `dll_shift_rst` are all high.
- R6: The divider pair (fractional, integer) is chosen as follows:
  - 151000 kHz → (19, 3)
  - 130000 kHz → (33, 2)
  - any other value → (27, 5)
- R7: `bypass_sel` then falls and the block waits for the PLL-busy flag to clear. Both DLL resets are released only with `bypass_sel` low, and the block then waits for `dll_locked`.
- R8: `sref_req` then drops. `done` pulses for exactly one cycle only after `dram_halted` has gone low, and `busy` stays high from the accepted start until that pulse.
- R9: A start pulse while `busy` is high has no effect: the run in progress keeps its frequency and no second run follows.
- R10: A wait that lasts `timeout_lim` cycles sets `err` and recovers:
  - a park timeout skips the writes and the clock change;
  - a crystal timeout skips the divider load;
  - every later step still runs.
  
  `err` holds until the next accepted start clears it.
- R11: After reset:
  - every control output is low;
  - `busy`, `done` and `err` are low;
  - the dividers read (27, 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a retune when idle |
| freq_khz | input | FREQ_W | Requested memory clock in kHz, captured at start |
| timeout_lim | input | TO_W | Cycle limit for each wait state |
| dram_halted | input | 1 | DRAM has entered self-refresh |
| busy_to_xtal | input | 1 | Clock mux still moving onto the crystal |
| busy_to_ref | input | 1 | Clock mux still moving back to the PLL |
| dll_locked | input | 1 | Interface DLL has locked |
| sref_req | output | 1 | Self-refresh request to the DRAM controller |
| bypass_sel | output | 1 | Select crystal bypass for the memory clock |
| dll_rst | output | 1 | DLL reset |
| dll_shift_rst | output | 1 | DLL shift-logic reset |
| frac_div | output | 6 | Fractional divider value |
| int_div | output | 6 | Integer divider value |
| reg_idx | output | 6 | Timing register index |
| reg_data | output | 32 | Timing register value |
| reg_wr | output | 1 | Register write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |

## Verification
The bench sweeps requested frequencies that sit exactly on and one kHz past each table threshold. An off-by-one comparison would show up as the wrong word stream at those points. A divider decode that matched ranges instead of exact codes would give the 130000 and 133000 requests the same pair.

Status responses from the modelled DRAM and clock mux arrive a cycle late. A sequencer that sampled a flag in the same cycle it issued the request would therefore skip ahead, and the bench catches this as writes outside self-refresh or divider changes off the crystal.

Three timeouts are forced: DRAM never halting, the mux stuck on the crystal, and the DLL never locking. A design that hung, forgot to restore the PLL path, or dropped the error flag early would be reported.

// File: rtl/mclk_retune_pkg.sv
`timescale 1ns/1ps
package mclk_retune_pkg;

  localparam int NUM_WORDS = 15;
  localparam int ENT_W     = $clog2(NUM_WORDS);
  localparam int IDX_W     = 6;
  localparam int WORD_W    = 32;
  localparam int DIV_W     = 6;
  localparam int TBL_W     = 3;
  localparam logic [IDX_W-1:0] FINAL_IDX = 6'd40;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PARK,
    ST_LOAD,
    ST_XTAL,
    ST_DIV,
    ST_PLL,
    ST_LOCK,
    ST_UNPARK,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [DIV_W-1:0] frac;
    logic [DIV_W-1:0] whole;
  } div_pair_t;

  // Threshold ladder; 60000/80000 and 133000/above collapse onto one table each.
  function automatic logic [TBL_W-1:0] pick_table(input logic [31:0] khz);
    if (khz <= 32'd24000)       return 3'd0;
    else if (khz <= 32'd48000)  return 3'd1;
    else if (khz <= 32'd60000)  return 3'd2;
    else if (khz <= 32'd80000)  return 3'd2;
    else if (khz <= 32'd96000)  return 3'd3;
    else if (khz <= 32'd120000) return 3'd4;
    else                        return 3'd5;
  endfunction

  // Register index written in each slot; the closing slot must be FINAL_IDX.
  function automatic logic [IDX_W-1:0] slot_index(input logic [ENT_W-1:0] ent);
    case (int'(ent))
      0:       return 6'd21;
      1:       return 6'd4;
      2:       return 6'd19;
      3:       return 6'd7;
      4:       return 6'd33;
      5:       return 6'd12;
      6:       return 6'd26;
      7:       return 6'd13;
      8:       return 6'd15;
      9:       return 6'd34;
      10:      return 6'd17;
      11:      return 6'd32;
      12:      return 6'd18;
      13:      return 6'd20;
      default: return FINAL_IDX;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] timing_word(input logic [TBL_W-1:0] tbl,
                                                    input logic [IDX_W-1:0] idx);
    logic [7:0]  hi;
    logic [15:0] lo;
    hi = {5'd0, tbl} + 8'd1;
    lo = {10'd0, idx} * ({13'd0, tbl} + 16'd1);
    return {hi, 2'b00, idx, lo};
  endfunction

  // 480 MHz reference * 18 / frac / whole
  function automatic div_pair_t pick_divider(input logic [31:0] khz);
    div_pair_t p;
    case (khz)
      32'd151000: begin p.frac = 6'd19; p.whole = 6'd3; end
      32'd130000: begin p.frac = 6'd33; p.whole = 6'd2; end
      default:    begin p.frac = 6'd27; p.whole = 6'd5; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mclk_timing_rom.sv
`timescale 1ns/1ps
module mclk_timing_rom
  import mclk_retune_pkg::*;
(
  input  logic [TBL_W-1:0]  tbl,
  input  logic [ENT_W-1:0]  ent,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  assign idx  = slot_index(ent);
  assign word = timing_word(tbl, idx);
endmodule

// File: rtl/mclk_wait_timer.sv
`timescale 1ns/1ps
module mclk_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             settled,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  // Status is trusted only from the second cycle in a state onward.
  assign settled = (cnt_q != '0);
  assign expired = settled && (cnt_q >= limit);
endmodule

// File: rtl/mclk_retune_seq.sv
`timescale 1ns/1ps
module mclk_retune_seq
  import mclk_retune_pkg::*;
#(
  parameter int FREQ_W = 18,
  parameter int TO_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_khz,
  input  logic [TO_W-1:0]   timeout_lim,
  input  logic              dram_halted,
  input  logic              busy_to_xtal,
  input  logic              busy_to_ref,
  input  logic              dll_locked,
  output logic              sref_req,
  output logic              bypass_sel,
  output logic              dll_rst,
  output logic              dll_shift_rst,
  output logic [DIV_W-1:0]  frac_div,
  output logic [DIV_W-1:0]  int_div,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [WORD_W-1:0] reg_data,
  output logic              reg_wr,
  output logic              busy,
  output logic              done,
  output logic              err
);

  seq_state_e        state_q, nxt_s;
  logic [FREQ_W-1:0] freq_q;
  logic [ENT_W-1:0]  ent_q;
  logic [DIV_W-1:0]  frac_q, whole_q;
  logic              err_q;

  // Named internal events
  logic              start_acc;
  logic              is_wait, wait_cond, wait_pass, wait_fail;
  logic              settled, expired, tmr_clear;
  logic              last_write;
  logic [TBL_W-1:0]  tbl_w;
  logic [IDX_W-1:0]  rom_idx;
  logic [WORD_W-1:0] rom_word;
  div_pair_t         pair_w;

  assign start_acc = start && (state_q == ST_IDLE);
  assign tbl_w     = pick_table(32'(freq_q));
  assign pair_w    = pick_divider(32'(freq_q));

  mclk_timing_rom u_rom (
    .tbl  (tbl_w),
    .ent  (ent_q),
    .idx  (rom_idx),
    .word (rom_word)
  );

  mclk_wait_timer #(.CNT_W(TO_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .limit   (timeout_lim),
    .settled (settled),
    .expired (expired)
  );

  always_comb begin
    is_wait   = 1'b1;
    wait_cond = 1'b0;
    case (state_q)
      ST_PARK:   wait_cond = dram_halted;
      ST_XTAL:   wait_cond = !busy_to_xtal;
      ST_PLL:    wait_cond = !busy_to_ref;
      ST_LOCK:   wait_cond = dll_locked;
      ST_UNPARK: wait_cond = !dram_halted;
      default:   is_wait   = 1'b0;
    endcase
  end

  assign wait_pass  = is_wait && settled && wait_cond;
  assign wait_fail  = is_wait && expired && !wait_cond;
  assign last_write = (state_q == ST_LOAD) && (rom_idx == FINAL_IDX);

  always_comb begin
    nxt_s = state_q;
    case (state_q)
      ST_IDLE:   if (start_acc) nxt_s = ST_PARK;
      ST_PARK:   if (wait_pass) nxt_s = ST_LOAD;
                 else if (wait_fail) nxt_s = ST_UNPARK;
      ST_LOAD:   if (last_write) nxt_s = ST_XTAL;
      ST_XTAL:   if (wait_pass) nxt_s = ST_DIV;
                 else if (wait_fail) nxt_s = ST_PLL;
      ST_DIV:    nxt_s = ST_PLL;
      ST_PLL:    if (wait_pass || wait_fail) nxt_s = ST_LOCK;
      ST_LOCK:   if (wait_pass || wait_fail) nxt_s = ST_UNPARK;
      ST_UNPARK: if (wait_pass || wait_fail) nxt_s = ST_DONE;
      ST_DONE:   nxt_s = ST_IDLE;
      default:   nxt_s = ST_IDLE;
    endcase
  end

  assign tmr_clear = (nxt_s != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      freq_q  <= '0;
      ent_q   <= '0;
      frac_q  <= 6'd27;
      whole_q <= 6'd5;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt_s;
      if (start_acc) freq_q <= freq_khz;
      if (state_q == ST_LOAD) ent_q <= ent_q + 1'b1;
      else                    ent_q <= '0;
      if ((state_q == ST_XTAL) && wait_pass) begin
        frac_q  <= pair_w.frac;
        whole_q <= pair_w.whole;
      end
      if (start_acc)      err_q <= 1'b0;
      else if (wait_fail) err_q <= 1'b1;
    end
  end

  // Moore decode of the control outputs
  assign sref_req      = (state_q == ST_PARK) || (state_q == ST_LOAD) ||
                         (state_q == ST_XTAL) || (state_q == ST_DIV)  ||
                         (state_q == ST_PLL)  || (state_q == ST_LOCK);
  assign bypass_sel    = (state_q == ST_XTAL) || (state_q == ST_DIV);
  assign dll_rst       = (state_q == ST_DIV)  || (state_q == ST_PLL);
  assign dll_shift_rst = dll_rst;
  assign reg_wr        = (state_q == ST_LOAD);
  assign reg_idx       = reg_wr ? rom_idx  : '0;
  assign reg_data      = reg_wr ? rom_word : '0;
  assign frac_div      = frac_q;
  assign int_div       = whole_q;
  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign err           = err_q;

endmodule

// File: rtl/mclk_retune_chk.sv
`timescale 1ns/1ps
module mclk_retune_chk
  import mclk_retune_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             sref_req,
  input logic             dram_halted,
  input logic             reg_wr,
  input logic             bypass_sel,
  input logic             dll_rst,
  input logic             dll_shift_rst,
  input logic [DIV_W-1:0] frac_div,
  input logic [DIV_W-1:0] int_div,
  input logic             start_acc,
  input logic             wait_fail
);

  // R1
  wr_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (sref_req && dram_halted))
    else $error("write outside self-refresh");

  // R5
  div_on_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(frac_div) || !$stable(int_div)) |-> (bypass_sel && dll_rst && dll_shift_rst))
    else $error("divider changed off crystal");

  // R7
  dll_release_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_rst) |-> !bypass_sel)
    else $error("DLL released on crystal");

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R8
  done_unparked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sref_req && !dram_halted))
    else $error("done while DRAM parked");

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy)
    else $error("busy dropped before done");

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_fail |=> err)
    else $error("timeout without error");

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_acc) |=> err)
    else $error("error flag lost");

endmodule

bind mclk_retune_seq mclk_retune_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .err           (err),
  .sref_req      (sref_req),
  .dram_halted   (dram_halted),
  .reg_wr        (reg_wr),
  .bypass_sel    (bypass_sel),
  .dll_rst       (dll_rst),
  .dll_shift_rst (dll_shift_rst),
  .frac_div      (frac_div),
  .int_div       (int_div),
  .start_acc     (start_acc),
  .wait_fail     (wait_fail)
);

// File: tb/mclk_retune_seq_test.sv
`timescale 1ns/1ps
module mclk_retune_seq_test;

  localparam int FREQ_W = 18;
  localparam int TO_W   = 12;

  typedef struct packed {
    logic [31:0] khz;
    logic [2:0]  tbl;
    logic [5:0]  frac;
    logic [5:0]  dv;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{32'd1000,   3'd0, 6'd27, 6'd5},
    '{32'd24000,  3'd0, 6'd27, 6'd5},
    '{32'd24001,  3'd1, 6'd27, 6'd5},
    '{32'd48000,  3'd1, 6'd27, 6'd5},
    '{32'd48001,  3'd2, 6'd27, 6'd5},
    '{32'd60000,  3'd2, 6'd27, 6'd5},
    '{32'd80000,  3'd2, 6'd27, 6'd5},
    '{32'd80001,  3'd3, 6'd27, 6'd5},
    '{32'd96000,  3'd3, 6'd27, 6'd5},
    '{32'd96001,  3'd4, 6'd27, 6'd5},
    '{32'd120000, 3'd4, 6'd27, 6'd5},
    '{32'd130000, 3'd5, 6'd33, 6'd2},
    '{32'd133000, 3'd5, 6'd27, 6'd5},
    '{32'd151000, 3'd5, 6'd19, 6'd3},
    '{32'd200000, 3'd5, 6'd27, 6'd5}
  };

  localparam int ORDER [15] = '{21, 4, 19, 7, 33, 12, 26, 13, 15, 34, 17, 32, 18, 20, 40};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, start;
  logic [FREQ_W-1:0] freq_khz;
  logic [TO_W-1:0]   timeout_lim;
  logic              dram_halted, busy_to_xtal, busy_to_ref, dll_locked;
  logic              sref_req, bypass_sel, dll_rst, dll_shift_rst, reg_wr;
  logic              busy, done, err;
  logic [5:0]        frac_div, int_div, reg_idx;
  logic [31:0]       reg_data;

  mclk_retune_seq #(.FREQ_W(FREQ_W), .TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
    .timeout_lim(timeout_lim), .dram_halted(dram_halted),
    .busy_to_xtal(busy_to_xtal), .busy_to_ref(busy_to_ref),
    .dll_locked(dll_locked), .sref_req(sref_req), .bypass_sel(bypass_sel),
    .dll_rst(dll_rst), .dll_shift_rst(dll_shift_rst), .frac_div(frac_div),
    .int_div(int_div), .reg_idx(reg_idx), .reg_data(reg_data),
    .reg_wr(reg_wr), .busy(busy), .done(done), .err(err)
  );

  // ---------------- environment model ----------------
  logic       halt_ok, lock_ok, xtal_stuck;
  logic [1:0] halt_pipe;
  logic       byp_seen;
  logic [1:0] xcnt, rcnt;
  logic [2:0] lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_pipe <= '0; byp_seen <= 1'b0; xcnt <= '0; rcnt <= '0; lcnt <= '0;
    end else begin
      halt_pipe <= {halt_pipe[0], sref_req & halt_ok};
      byp_seen  <= bypass_sel;
      if (bypass_sel && !byp_seen)      xcnt <= 2'd3;
      else if (xcnt != 0)               xcnt <= xcnt - 2'd1;
      if (!bypass_sel && byp_seen)      rcnt <= 2'd3;
      else if (rcnt != 0)               rcnt <= rcnt - 2'd1;
      if (dll_rst)                      lcnt <= '0;
      else if (lcnt != 3'd7)            lcnt <= lcnt + 3'd1;
    end
  end

  assign dram_halted  = halt_pipe[1];
  assign busy_to_xtal = (xcnt != 0) || (xtal_stuck && bypass_sel);
  assign busy_to_ref  = (rcnt != 0);
  assign dll_locked   = lock_ok && (lcnt >= 3'd4);

  // ---------------- monitor ----------------
  int         wr_total = 0, done_total = 0;
  int         viol_park = 0, viol_div = 0, viol_byp = 0, viol_done = 0;
  logic [5:0] wr_idx [512];
  logic [31:0] wr_dat [512];
  logic [5:0] last_idx = '0;
  logic       mon_byp = 1'b0, mon_done = 1'b0;
  logic [5:0] frac_prev = 6'd27, int_prev = 6'd5;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        if (!(sref_req && dram_halted)) viol_park++;
        if (wr_total < 512) begin
          wr_idx[wr_total] = reg_idx;
          wr_dat[wr_total] = reg_data;
        end
        wr_total++;
        last_idx = reg_idx;
      end
      if ((frac_div != frac_prev || int_div != int_prev) &&
          !(bypass_sel && dll_rst && dll_shift_rst)) viol_div++;
      if (bypass_sel && !mon_byp && last_idx != 6'd40) viol_byp++;
      if (done) begin
        done_total++;
        if (mon_done || sref_req || dram_halted || bypass_sel || dll_rst) viol_done++;
      end
      frac_prev = frac_div;
      int_prev  = int_div;
      mon_byp   = bypass_sel;
      mon_done  = done;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int tbl, input int idx);
    return 32'((tbl + 1) * 16777216 + idx * 65536 + ((idx * (tbl + 1)) % 65536));
  endfunction

  task automatic do_run(input logic [FREQ_W-1:0] khz, input bit poke,
                        output int base_wr, output int base_done);
    base_wr   = wr_total;
    base_done = done_total;
    @(negedge clk);
    freq_khz = khz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(busy == 1'b1, "R8", "busy mid-run", longint'(busy), 1);
      freq_khz = 18'd24000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3000 && done_total == base_done; k++) @(negedge clk);
    chk(done_total == base_done + 1, "R8", "done pulses", done_total - base_done, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_stream(input int base, input int tbl);
    chk(wr_total - base == 15, "R4", "write count", wr_total - base, 15);
    for (int e = 0; e < 15; e++) begin
      if (base + e < 512) begin
        chk(wr_idx[base + e] == 6'(ORDER[e]), "R4", "write index",
            longint'(wr_idx[base + e]), ORDER[e]);
        chk(wr_dat[base + e] == exp_word(tbl, ORDER[e]), "R3", "write data",
            longint'(wr_dat[base + e]), longint'(exp_word(tbl, ORDER[e])));
      end
    end
  endtask

  task automatic chk_safe(input string req);
    chk(!sref_req && !bypass_sel && !dll_rst && !dll_shift_rst && !busy, req,
        "idle controls", longint'({sref_req, bypass_sel, dll_rst, dll_shift_rst, busy}), 0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int bw, bd;
    rst_n = 1'b0; start = 1'b0; freq_khz = '0; timeout_lim = 12'd50;
    halt_ok = 1'b1; lock_ok = 1'b1; xtal_stuck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!sref_req && !bypass_sel && !dll_rst && !dll_shift_rst && !reg_wr, "R11",
        "controls after reset", longint'({sref_req, bypass_sel, dll_rst, dll_shift_rst, reg_wr}), 0);
    chk(!busy && !done && !err, "R11", "status after reset", longint'({busy, done, err}), 0);
    chk(frac_div == 6'd27 && int_div == 6'd5, "R11", "dividers after reset",
        longint'({frac_div, int_div}), longint'({6'd27, 6'd5}));

    // Vector sweep: R2 R3 R4 R6 and sequence ordering
    foreach (VECS[v]) begin
      do_run(VECS[v].khz[FREQ_W-1:0], 1'b0, bw, bd);
      chk_stream(bw, int'(VECS[v].tbl));
      chk(frac_div == VECS[v].frac, "R6", "frac", longint'(frac_div), longint'(VECS[v].frac));
      chk(int_div == VECS[v].dv, "R6", "int", longint'(int_div), longint'(VECS[v].dv));
      chk(err == 1'b0, "R10", "no error on clean run", longint'(err), 0);
      chk_safe("R7");
    end
    chk(viol_park == 0, "R1", "writes outside self-refresh", viol_park, 0);
    chk(viol_div == 0, "R5", "divider change off crystal", viol_div, 0);
    chk(viol_byp == 0, "R5", "bypass before index 40", viol_byp, 0);
    chk(viol_done == 0, "R8", "done pulse conditions", viol_done, 0);

    // R9 start while busy is ignored
    do_run(18'd151000, 1'b1, bw, bd);
    chk_stream(bw, 5);
    chk(frac_div == 6'd19 && int_div == 6'd3, "R9", "divider kept",
        longint'({frac_div, int_div}), longint'({6'd19, 6'd3}));
    repeat (30) @(negedge clk);
    chk(done_total == bd + 1 && !busy, "R9", "no second run", done_total - bd, 1);

    // R10 park timeout: no writes, no clock change
    halt_ok = 1'b0; timeout_lim = 12'd10;
    do_run(18'd130000, 1'b0, bw, bd);
    chk(err == 1'b1, "R10", "park timeout err", longint'(err), 1);
    chk(wr_total == bw, "R10", "writes after park timeout", wr_total - bw, 0);
    chk(frac_div == 6'd19, "R10", "frac kept after park timeout", longint'(frac_div), 19);
    chk_safe("R10");
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R10", "err sticky", longint'(err), 1);
    halt_ok = 1'b1;

    // R10 crystal timeout: divider load skipped, PLL restored
    xtal_stuck = 1'b1;
    do_run(18'd130000, 1'b0, bw, bd);
    chk_stream(bw, 5);
    chk(err == 1'b1, "R10", "xtal timeout err", longint'(err), 1);
    chk(frac_div == 6'd19 && int_div == 6'd3, "R10", "divider unchanged",
        longint'({frac_div, int_div}), longint'({6'd19, 6'd3}));
    chk_safe("R10");
    xtal_stuck = 1'b0;

    // R10 lock timeout: DLL released, self-refresh dropped
    lock_ok = 1'b0;
    do_run(18'd96000, 1'b0, bw, bd);
    chk(err == 1'b1, "R10", "lock timeout err", longint'(err), 1);
    chk(frac_div == 6'd27 && int_div == 6'd5, "R6", "divider after lock timeout",
        longint'({frac_div, int_div}), longint'({6'd27, 6'd5}));
    chk_safe("R10");
    lock_ok = 1'b1; timeout_lim = 12'd50;

    // R10 error cleared by next accepted start
    do_run(18'd130000, 1'b0, bw, bd);
    chk(err == 1'b0, "R10", "err cleared", longint'(err), 0);
    chk(frac_div == 6'd33 && int_div == 6'd2, "R6", "divider after recovery",
        longint'({frac_div, int_div}), longint'({6'd33, 6'd2}));
    chk(viol_park == 0 && viol_div == 0 && viol_byp == 0 && viol_done == 0, "R1",
        "ordering across fault runs", viol_park + viol_div + viol_byp + viol_done, 0);

    summary();
    $finish;
  end

endmodule